// File: doc/BRIEF.md
# Address Range Permission Table

This block holds the access rules for one untrusted hardware accelerator and answers, for each address that accelerator tries to use, whether the access may go ahead. Every rule is one of two kinds. An exact rule covers a single address. A range rule covers every address between an inclusive lower bound and an inclusive upper bound. Each rule also carries a read permission bit and a write permission bit.

Software edits the table at run time through a management port. It can add a rule, invalidate the rule at a given index, or wipe the whole table. A lookup port takes an address and an access kind. One cycle later it returns a done strobe, a flag that says whether any rule matched, and the allow/deny verdict.

All rules sit in registers and are compared in parallel, in the manner of a CAM. Two build-time parameters set the policy. The first makes the table a whitelist or a blacklist. The second chooses how several matching rules combine: exhaustive, where all of them count, or first-match, where the lowest index decides.

Top module: `acc_rule_table`

## Requirements
- R1: After reset every entry is invalid, `mg_err` is 0 and `lk_done` is 0, so no lookup matches.
- R2: `lk_done` is 1 in the cycle that follows a cycle with `lk_valid` high. It is 0 in every other cycle.
- R3: An exact rule (`mg_range`=0) matches only an address equal to its `mg_lo` value.
- R4: A range rule (`mg_range`=1) matches when `mg_lo <= addr <= mg_hi`, with unsigned comparison and both bounds included.
- R5: In whitelist mode (`WHITELIST`=1) an access is allowed only if the combined matching permission has the bit for that access kind set: `mg_rd` for reads (`lk_write`=0), `mg_wr` for writes (`lk_write`=1). An access that matches no rule is denied.
- R6: In blacklist mode (`WHITELIST`=0) the permission bits mark forbidden access kinds. An access is denied only if the combined matching permission has the bit for its kind set. An access that matches no rule is allowed.
- R7: With `EXHAUSTIVE`=1 the read bits of all matching rules are ORed together, and so are their write bits.
- R8: With `EXHAUSTIVE`=0 only the lowest-index matching rule supplies the permission bits.
- R9: `mg_op`=0 stores a rule in the lowest-index invalid slot. `mg_op`=1 invalidates slot `mg_idx`. `mg_op`=2 invalidates every slot and clears `mg_err`. `mg_op`=3 does nothing. An op takes effect only while `mg_valid` is 1.
- R10: An add issued while every slot is valid stores nothing and sets `mg_err`. The flag stays set until a clear-all or a reset.
- R11: When a lookup and a management op arrive in the same cycle, the lookup sees the table as it stood before that op.
- R12: `lk_hit` is 1 when at least one valid rule matched the looked-up address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mg_valid | input | 1 | Management op strobe |
| mg_op | input | 2 | 0 add, 1 invalidate index, 2 clear all, 3 none |
| mg_idx | input | IDX_W | Slot to invalidate |
| mg_range | input | 1 | New rule is a range (1) or an exact address (0) |
| mg_lo | input | ADDR_W | Exact address, or lower bound of the range |
| mg_hi | input | ADDR_W | Upper bound of the range |
| mg_rd | input | 1 | Read permission bit of the new rule |
| mg_wr | input | 1 | Write permission bit of the new rule |
| mg_err | output | 1 | Sticky flag for an add rejected because the table is full |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Address to check |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_done | output | 1 | Result strobe, one cycle after the request |
| lk_hit | output | 1 | At least one rule matched |
| lk_allow | output | 1 | The access is permitted |

## Verification
Two copies of the block run side by side on the same stimulus. One is built as an exhaustive whitelist and the other as a first-match blacklist, so each permission pattern separates the two ways of combining matches and the two polarities.

Directed cases cover several situations:
- addresses one below, on, and one above the bounds of a range rule, and addresses next to an exact rule;
- two rules on the same address carrying different permission bits, which tells OR-combining apart from lowest-index priority;
- an add that arrives in the same cycle as a lookup of that same address;
- an add into a full table;
- an add after slots have been freed, so the chosen slot shows up when it is invalidated again.

Random runs over a narrow address space mix adds, invalidations, clears and lookups, so matches and overlapping rules occur often.

// File: rtl/acc_rule_table.sv
module acc_rule_table #(
  parameter int ADDR_W = 32,
  parameter int N_RULES = 8,
  parameter bit WHITELIST = 1'b1,
  parameter bit EXHAUSTIVE = 1'b1,
  localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mg_valid,
  input  logic [1:0]        mg_op,
  input  logic [IDX_W-1:0]  mg_idx,
  input  logic              mg_range,
  input  logic [ADDR_W-1:0] mg_lo,
  input  logic [ADDR_W-1:0] mg_hi,
  input  logic              mg_rd,
  input  logic              mg_wr,
  output logic              mg_err,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_write,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_allow
);

  logic [N_RULES-1:0] vld, rng, prd, pwr, match;
  logic [ADDR_W-1:0]  lo [N_RULES];
  logic [ADDR_W-1:0]  hi [N_RULES];
  logic [IDX_W-1:0]   free_idx;
  logic               g_rd, g_wr;

  wire table_full = &vld;
  wire do_add = mg_valid && mg_op == 2'd0;
  wire do_inv = mg_valid && mg_op == 2'd1;
  wire do_clr = mg_valid && mg_op == 2'd2;

  always_comb begin
    for (int i = 0; i < N_RULES; i++)
      match[i] = vld[i] && (rng[i] ? (lk_addr >= lo[i] && lk_addr <= hi[i])
                                   : (lk_addr == lo[i]));
  end

  always_comb begin
    free_idx = '0;
    for (int i = N_RULES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  generate
    if (EXHAUSTIVE) begin : g_or_all
      assign g_rd = |(match & prd);
      assign g_wr = |(match & pwr);
    end else begin : g_first
      always_comb begin
        g_rd = 1'b0;
        g_wr = 1'b0;
        for (int i = N_RULES - 1; i >= 0; i--)
          if (match[i]) begin
            g_rd = prd[i];
            g_wr = pwr[i];
          end
      end
    end
  endgenerate

  wire granted = lk_write ? g_wr : g_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= '0;
      mg_err   <= 1'b0;
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_allow <= 1'b0;
    end else begin
      lk_done <= lk_valid;
      if (lk_valid) begin
        lk_hit   <= |match;
        lk_allow <= WHITELIST ? granted : !granted;
      end
      if (do_clr) begin
        vld    <= '0;
        mg_err <= 1'b0;
      end else if (do_inv) begin
        if (int'(mg_idx) < N_RULES) vld[mg_idx] <= 1'b0;
      end else if (do_add) begin
        if (table_full) mg_err <= 1'b1;
        else vld[free_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_add && !table_full) begin
      rng[free_idx] <= mg_range;
      prd[free_idx] <= mg_rd;
      pwr[free_idx] <= mg_wr;
      lo[free_idx]  <= mg_lo;
      hi[free_idx]  <= mg_hi;
    end
  end

  p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_done);
  p_full_add_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (do_add && table_full) |=> mg_err);
  p_full_add_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (do_add && table_full) |=> $stable(vld));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_err && !do_clr) |=> mg_err);
  p_miss_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_hit) |-> (lk_allow == !WHITELIST));
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (vld == '0 && !mg_err));

endmodule

// File: tb/acc_rule_table_tb_top.sv
`timescale 1ns/1ps
module acc_rule_table_tb_top;
  localparam int AW = 8;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic mg_valid = 0, mg_range = 0, mg_rd = 0, mg_wr = 0;
  logic [1:0] mg_op = 2'd3;
  logic [IW-1:0] mg_idx = '0;
  logic [AW-1:0] mg_lo = '0, mg_hi = '0, lk_addr = '0;
  logic lk_valid = 0, lk_write = 0;
  logic err_a, done_a, hit_a, allow_a;
  logic err_b, done_b, hit_b, allow_b;

  acc_rule_table #(.ADDR_W(AW), .N_RULES(N), .WHITELIST(1'b1), .EXHAUSTIVE(1'b1)) dut_i (
    .clk, .rst_n, .mg_valid, .mg_op, .mg_idx, .mg_range, .mg_lo, .mg_hi, .mg_rd, .mg_wr,
    .mg_err(err_a), .lk_valid, .lk_addr, .lk_write,
    .lk_done(done_a), .lk_hit(hit_a), .lk_allow(allow_a));

  acc_rule_table #(.ADDR_W(AW), .N_RULES(N), .WHITELIST(1'b0), .EXHAUSTIVE(1'b0)) dut_bl_i (
    .clk, .rst_n, .mg_valid, .mg_op, .mg_idx, .mg_range, .mg_lo, .mg_hi, .mg_rd, .mg_wr,
    .mg_err(err_b), .lk_valid, .lk_addr, .lk_write,
    .lk_done(done_b), .lk_hit(hit_b), .lk_allow(allow_b));

  int n_chk = 0, n_fail = 0;
  bit m_vld[N], m_rng[N], m_rd[N], m_wr[N];
  logic [AW-1:0] m_lo[N], m_hi[N];
  bit m_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_eval(input logic [AW-1:0] a, input bit w,
                                          input bit exh, input bit wl);
    bit h = 0, gr = 0, gw = 0;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && (m_rng[i] ? (a >= m_lo[i] && a <= m_hi[i]) : a == m_lo[i])) begin
        if (exh) begin gr |= m_rd[i]; gw |= m_wr[i]; end
        else if (!h) begin gr = m_rd[i]; gw = m_wr[i]; end
        h = 1;
      end
    end
    return {h, wl ? (w ? gw : gr) : !(w ? gw : gr)};
  endfunction

  task automatic ref_apply(input bit mv, input logic [1:0] op, input int idx, input bit rg,
                           input logic [AW-1:0] lo, input logic [AW-1:0] hi, input bit rd, input bit wr);
    int slot = -1;
    if (!mv) return;
    case (op)
      2'd0: begin
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        if (slot < 0) m_err = 1;
        else begin
          m_vld[slot] = 1; m_rng[slot] = rg; m_rd[slot] = rd; m_wr[slot] = wr;
          m_lo[slot] = lo; m_hi[slot] = hi;
        end
      end
      2'd1: m_vld[idx] = 0;
      2'd2: begin for (int i = 0; i < N; i++) m_vld[i] = 0; m_err = 0; end
      default: ;
    endcase
  endtask

  task automatic step(input bit mv, input logic [1:0] op, input int idx, input bit rg,
                      input logic [AW-1:0] lo, input logic [AW-1:0] hi, input bit rd, input bit wr,
                      input bit lv, input logic [AW-1:0] la, input bit lw, input string tag);
    logic [1:0] ea, eb;
    mg_valid = mv; mg_op = op; mg_idx = IW'(idx); mg_range = rg; mg_lo = lo; mg_hi = hi;
    mg_rd = rd; mg_wr = wr; lk_valid = lv; lk_addr = la; lk_write = lw;
    ea = ref_eval(la, lw, 1, 1);
    eb = ref_eval(la, lw, 0, 0);
    ref_apply(mv, op, idx, rg, lo, hi, rd, wr);
    @(negedge clk);
    mg_valid = 0; lk_valid = 0;
    chk(done_a == lv && done_b == lv, {tag, " R2 done"}, int'({done_a, done_b}), int'({lv, lv}));
    chk(err_a == m_err && err_b == m_err, {tag, " R10 err"}, int'({err_a, err_b}), int'({m_err, m_err}));
    if (lv) begin
      chk(hit_a == ea[1] && hit_b == eb[1], {tag, " R12 hit"}, int'({hit_a, hit_b}), int'({ea[1], eb[1]}));
      chk(allow_a == ea[0], {tag, " R5 R7 allow wl/exh"}, int'(allow_a), int'(ea[0]));
      chk(allow_b == eb[0], {tag, " R6 R8 allow bl/first"}, int'(allow_b), int'(eb[0]));
    end
  endtask

  task automatic add(input bit rg, input int lo, input int hi, input bit rd, input bit wr, input string tag);
    step(1, 2'd0, 0, rg, AW'(lo), AW'(hi), rd, wr, 0, '0, 0, tag);
  endtask
  task automatic look(input int a, input bit w, input string tag);
    step(0, 2'd3, 0, 0, '0, '0, 0, 0, 1, AW'(a), w, tag);
  endtask
  task automatic inv(input int idx, input string tag);
    step(1, 2'd1, idx, 0, '0, '0, 0, 0, 0, '0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk(done_a == 0 && err_a == 0 && done_b == 0 && err_b == 0, "R1 reset outputs",
        int'({done_a, err_a, done_b, err_b}), 0);
    rst_n = 1;
    @(negedge clk);
    look(5, 0, "R1 empty table");
    add(0, 10, 0, 1, 0, "R9 add exact");
    look(10, 0, "R3 exact hit read");
    look(10, 1, "R5 R6 exact write");
    look(11, 0, "R3 neighbour above");
    look(9, 0, "R3 neighbour below");
    add(1, 20, 30, 0, 1, "R9 add range");
    look(20, 1, "R4 lower bound");
    look(30, 1, "R4 upper bound");
    look(31, 1, "R4 above");
    look(19, 1, "R4 below");
    look(25, 0, "R4 inside read");
    add(0, 10, 0, 0, 1, "R9 add dup");
    look(10, 1, "R7 R8 overlap write");
    look(10, 0, "R7 R8 overlap read");
    step(1, 2'd0, 0, 0, AW'(40), '0, 1, 1, 1, AW'(40), 0, "R11 same cycle");
    look(40, 0, "R11 after insert");
    inv(1, "R9 free slot1");
    inv(3, "R9 free slot3");
    add(0, 50, 0, 1, 0, "R9 reuse");
    look(50, 0, "R9 reuse hit");
    inv(1, "R9 drop slot1");
    look(50, 0, "R9 lowest slot taken");
    for (int i = 0; i < N; i++) add(0, 100 + i, 0, 1, 1, "R10 fill");
    look(100 + N - 1, 0, "R10 not stored");
    inv(0, "R10 sticky after inv");
    add(0, 200, 0, 1, 1, "R10 add after free");
    look(200, 0, "R10 stored after free");
    step(1, 2'd2, 0, 0, '0, '0, 0, 0, 0, '0, 0, "R9 clear all");
    look(100, 0, "R9 cleared");
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 99);
      int lo = $urandom_range(0, 40);
      bit mv = r < 35;
      logic [1:0] op = (r < 22) ? 2'd0 : (r < 32) ? 2'd1 : (r < 34) ? 2'd2 : 2'd3;
      step(mv, op, $urandom_range(0, N - 1), 1'($urandom_range(0, 1)), AW'(lo),
           AW'(lo + $urandom_range(0, 8)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) != 0), AW'($urandom_range(0, 48)), 1'($urandom_range(0, 1)),
           "R3 R4 R7 R8 R11 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule